// File: doc/BRIEF.md
# Four-Bit Overlapping-Parity Single-Error Corrector

This block guards a 4-bit data nibble with four overlapping even-parity checks. On the send side it turns a nibble into an 8-bit protected word: the data sits in the low half and the four check bits sit in the high half. On the receive side it recomputes the checks from the received data bits and XORs them with the received check bits. The result is a 4-bit syndrome. The syndrome tells the receiver one of four things: the word is clean, one data bit flipped (which the block repairs), one check bit flipped (data is already good), or the pattern cannot come from one flipped bit.

The two directions are independent. Each accepts a word when its input valid is high and presents a registered result one clock later with a matching output valid. The check groups are: group 1 over data bits 0,1,2; group 2 over bits 1,2,3; group 3 over bits 2,3,0; group 4 over all four bits. One group spans every data bit, so the syndrome code differs from the textbook positional code.

Top module: `par4_codec`

## Requirements
- R1: The encoder emits `enc_word_o = {c3,c2,c1,c0,d3,d2,d1,d0}`, where c0 = d0^d1^d2, c1 = d1^d2^d3, c2 = d2^d3^d0 and c3 = d0^d1^d2^d3.
- R2: `enc_valid_o` is high exactly one cycle after `enc_valid_i` was high, and `enc_word_o` then holds the word for the data accepted in that cycle.
- R3: One cycle after `dec_valid_i`, `dec_valid_o` is high and `dec_syndrome_o[g]` equals the check recomputed from `dec_word_i[3:0]` for group g+1, XOR `dec_word_i[4+g]`.
- R4: A zero syndrome raises no flag, and `dec_data_o` equals the received data bits.
- R5: Syndrome 4'b1101 flips data bit 0, 4'b1011 flips bit 1, 4'b1111 flips bit 2, and 4'b1110 flips bit 3. Each of these raises `dec_fixed_o`.
- R6: A syndrome with exactly one bit set raises `dec_parerr_o` and passes the received data through unchanged.
- R7: Any other non-zero syndrome raises `dec_uncorr_o` and passes the received data through unchanged.
- R8: At most one of `dec_fixed_o`, `dec_parerr_o` and `dec_uncorr_o` is high in any cycle.
- R9: While an input valid is low, the matching output valid goes low one cycle later, and the data, syndrome and flag outputs keep their previous values.
- R10: A synchronous active-low reset clears every output to zero, whatever the inputs are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_valid_i | input | 1 | Encoder input qualifier |
| enc_data_i | input | 4 | Nibble to protect |
| enc_valid_o | output | 1 | Encoder result qualifier |
| enc_word_o | output | 8 | Protected word, checks in [7:4] |
| dec_valid_i | input | 1 | Decoder input qualifier |
| dec_word_i | input | 8 | Received protected word |
| dec_valid_o | output | 1 | Decoder result qualifier |
| dec_data_o | output | 4 | Repaired or passed-through nibble |
| dec_syndrome_o | output | 4 | Per-group mismatch bits |
| dec_fixed_o | output | 1 | A data bit was flipped back |
| dec_parerr_o | output | 1 | A single check bit was wrong |
| dec_uncorr_o | output | 1 | Syndrome not explained by one error |

## Verification
Both the protected word and the full decode result are due exactly one rising edge after the input word is accepted. The bench drives inputs on falling edges and compares outputs on the next falling edge, once the register has been loaded. A driver queues the expected result for each accepted word, and a monitor pops one entry for every cycle in which an output valid is high. A queue that is empty or left over therefore shows a result that came a cycle early, a cycle late, or not at all. The hold case and the reset case are sampled on the falling edges after the idle or reset cycle.

// File: rtl/par4_pkg.sv
// Package: shared widths, check-group masks and decode flag type.
// Assumes a 4-bit nibble with four groups; masks are read bit j = data bit j.
package par4_pkg;
    localparam int DW = 4;
    localparam int PW = 4;
    localparam int CW = DW + PW;

    // Entry g is the set of data bits covered by check group g+1.
    localparam logic [PW-1:0][DW-1:0] GRP_MASK = {4'b1111, 4'b1101, 4'b1110, 4'b0111};

    typedef struct packed {
        logic fixed;
        logic parerr;
        logic uncorr;
    } dec_flags_t;

    // Syndrome signature produced when data bit j alone is flipped.
    function automatic logic [PW-1:0] col_sig(input int j);
        logic [PW-1:0] s;
        for (int g = 0; g < PW; g++) s[g] = GRP_MASK[g][j];
        return s;
    endfunction
endpackage

// File: rtl/par4_parity_gen.sv
// Module: par4_parity_gen
// Computes the even parity of every check group for one nibble.
// Purely combinational; assumes GRP_MASK from par4_pkg defines the groups.
module par4_parity_gen
    import par4_pkg::*;
(
    input  logic [DW-1:0] data_i,
    output logic [PW-1:0] par_o
);
    for (genvar g = 0; g < PW; g++) begin : g_grp
        // One XOR tree per group over its masked data bits.
        assign par_o[g] = ^(data_i & GRP_MASK[g]);
    end
endmodule

// File: rtl/par4_syndrome_map.sv
// Module: par4_syndrome_map
// Classifies a syndrome and repairs a single flipped data bit.
// Combinational; assumes every data-bit signature has at least three ones,
// so it never collides with a single-check-bit syndrome.
module par4_syndrome_map
    import par4_pkg::*;
(
    input  logic [PW-1:0] syn_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output dec_flags_t    flags_o
);
    logic [DW-1:0] hit;
    logic          single;
    logic          nonzero;

    for (genvar j = 0; j < DW; j++) begin : g_col
        localparam logic [PW-1:0] SIG = col_sig(j);
        // Flag data bit j when the syndrome equals its signature.
        assign hit[j] = (syn_i == SIG);
    end

    // Classify the syndrome and apply the repair mask.
    always_comb begin
        nonzero        = |syn_i;
        single         = nonzero && ((syn_i & (syn_i - 1'b1)) == '0);
        data_o         = data_i ^ hit;
        flags_o.fixed  = |hit;
        flags_o.parerr = single;
        flags_o.uncorr = nonzero && !single && !(|hit);
    end
endmodule

// File: rtl/par4_encoder.sv
// Module: par4_encoder
// Registers the protected word {checks, data} one cycle after a valid nibble.
// Assumes synchronous active-low reset; the word holds while valid is low.
module par4_encoder
    import par4_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic [CW-1:0] word_o
);
    logic [PW-1:0] par;

    par4_parity_gen i_gen (
        .data_i (data_i),
        .par_o  (par)
    );

    // Output register: load on valid, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) word_o <= {par, data_i};
        end
    end
endmodule

// File: rtl/par4_decoder.sv
// Module: par4_decoder
// Recomputes checks, forms the syndrome, repairs and classifies; one-cycle latency.
// Assumes synchronous active-low reset; results hold while valid is low.
module par4_decoder
    import par4_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [CW-1:0] word_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    output logic [PW-1:0] syn_o,
    output dec_flags_t    flags_o
);
    logic [PW-1:0] par_rx;
    logic [PW-1:0] syn;
    logic [DW-1:0] fixed_data;
    dec_flags_t    flags;

    par4_parity_gen i_gen (
        .data_i (word_i[DW-1:0]),
        .par_o  (par_rx)
    );

    // Mismatch between recomputed and received checks.
    assign syn = par_rx ^ word_i[CW-1:DW];

    par4_syndrome_map i_map (
        .syn_i   (syn),
        .data_i  (word_i[DW-1:0]),
        .data_o  (fixed_data),
        .flags_o (flags)
    );

    // Output register: load results on valid, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            syn_o   <= '0;
            flags_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o  <= fixed_data;
                syn_o   <= syn;
                flags_o <= flags;
            end
        end
    end
endmodule

// File: rtl/par4_codec.sv
// Module: par4_codec
// Top level: independent encode and decode paths for the 4-bit parity code.
// Assumes one clock and a synchronous active-low reset shared by both paths.
module par4_codec
    import par4_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enc_valid_i,
    input  logic [3:0] enc_data_i,
    output logic       enc_valid_o,
    output logic [7:0] enc_word_o,
    input  logic       dec_valid_i,
    input  logic [7:0] dec_word_i,
    output logic       dec_valid_o,
    output logic [3:0] dec_data_o,
    output logic [3:0] dec_syndrome_o,
    output logic       dec_fixed_o,
    output logic       dec_parerr_o,
    output logic       dec_uncorr_o
);
    dec_flags_t flags;

    par4_encoder i_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .word_o  (enc_word_o)
    );

    par4_decoder i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (dec_valid_i),
        .word_i  (dec_word_i),
        .valid_o (dec_valid_o),
        .data_o  (dec_data_o),
        .syn_o   (dec_syndrome_o),
        .flags_o (flags)
    );

    // Unpack the flag struct onto plain ports.
    assign dec_fixed_o  = flags.fixed;
    assign dec_parerr_o = flags.parerr;
    assign dec_uncorr_o = flags.uncorr;
endmodule

// File: rtl/par4_codec_chk.sv
// Module: par4_codec_chk
// Port-level temporal properties for par4_codec, attached by bind below.
module par4_codec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enc_valid_i,
    input logic [3:0] enc_data_i,
    input logic       enc_valid_o,
    input logic [7:0] enc_word_o,
    input logic       dec_valid_i,
    input logic [7:0] dec_word_i,
    input logic       dec_valid_o,
    input logic [3:0] dec_data_o,
    input logic [3:0] dec_syndrome_o,
    input logic       dec_fixed_o,
    input logic       dec_parerr_o,
    input logic       dec_uncorr_o
);
    // R2: the accepted nibble appears in the low half of the word next cycle.
    p_enc_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> (enc_valid_o && enc_word_o[3:0] == $past(enc_data_i)));

    // R8: the three outcome flags are mutually exclusive.
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_fixed_o, dec_parerr_o, dec_uncorr_o}));

    // R4: a clean syndrome raises no flag and keeps the received data.
    p_clean_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syndrome_o == 4'b0000) |->
        (!dec_fixed_o && !dec_parerr_o && !dec_uncorr_o));

    // R6: one received check bit wrong leaves the data untouched.
    p_par_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && $countones(dec_word_i[7:4] ^ {^dec_word_i[3:0],
            dec_word_i[0]^dec_word_i[2]^dec_word_i[3],
            dec_word_i[1]^dec_word_i[2]^dec_word_i[3],
            dec_word_i[0]^dec_word_i[1]^dec_word_i[2]}) == 1)
        |=> (dec_parerr_o && dec_data_o == $past(dec_word_i[3:0])));

    // R9: decoder results hold while no word is offered.
    p_dec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid_i && $past(rst_n)) |=> (!dec_valid_o && $stable(dec_data_o)
            && $stable(dec_syndrome_o)));

    // R3: a decode result follows every accepted received word.
    p_dec_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);
endmodule

bind par4_codec par4_codec_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enc_valid_i    (enc_valid_i),
    .enc_data_i     (enc_data_i),
    .enc_valid_o    (enc_valid_o),
    .enc_word_o     (enc_word_o),
    .dec_valid_i    (dec_valid_i),
    .dec_word_i     (dec_word_i),
    .dec_valid_o    (dec_valid_o),
    .dec_data_o     (dec_data_o),
    .dec_syndrome_o (dec_syndrome_o),
    .dec_fixed_o    (dec_fixed_o),
    .dec_parerr_o   (dec_parerr_o),
    .dec_uncorr_o   (dec_uncorr_o)
);

// File: tb/test_par4_codec.sv
// Scoreboard bench: driver tasks queue expected results, monitors compare them.
module test_par4_codec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_valid_i = 1'b0;
    logic [3:0] enc_data_i = '0;
    logic       enc_valid_o;
    logic [7:0] enc_word_o;
    logic       dec_valid_i = 1'b0;
    logic [7:0] dec_word_i = '0;
    logic       dec_valid_o;
    logic [3:0] dec_data_o;
    logic [3:0] dec_syndrome_o;
    logic       dec_fixed_o;
    logic       dec_parerr_o;
    logic       dec_uncorr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [3:0] data;
        logic [3:0] syn;
        logic [2:0] flags;   // {fixed, parerr, uncorr}
        string      req;
    } dec_exp_t;

    logic [7:0] enc_q[$];
    dec_exp_t   dec_q[$];

    always #2.5 clk = ~clk;

    par4_codec i_par4_codec (
        .clk            (clk),
        .rst_n          (rst_n),
        .enc_valid_i    (enc_valid_i),
        .enc_data_i     (enc_data_i),
        .enc_valid_o    (enc_valid_o),
        .enc_word_o     (enc_word_o),
        .dec_valid_i    (dec_valid_i),
        .dec_word_i     (dec_word_i),
        .dec_valid_o    (dec_valid_o),
        .dec_data_o     (dec_data_o),
        .dec_syndrome_o (dec_syndrome_o),
        .dec_fixed_o    (dec_fixed_o),
        .dec_parerr_o   (dec_parerr_o),
        .dec_uncorr_o   (dec_uncorr_o)
    );

    // Model of the check bits as written in R1.
    function automatic logic [3:0] m_chk(input logic [3:0] d);
        return {d[0]^d[1]^d[2]^d[3], d[2]^d[3]^d[0], d[1]^d[2]^d[3], d[0]^d[1]^d[2]};
    endfunction

    // Model of the decode outcome from R3..R7.
    function automatic dec_exp_t m_dec(input logic [7:0] w);
        dec_exp_t e;
        e.syn  = m_chk(w[3:0]) ^ w[7:4];
        e.data = w[3:0];
        case (e.syn)
            4'b0000: begin e.flags = 3'b000; e.req = "R4"; end
            4'b1101: begin e.data[0] = ~w[0]; e.flags = 3'b100; e.req = "R5"; end
            4'b1011: begin e.data[1] = ~w[1]; e.flags = 3'b100; e.req = "R5"; end
            4'b1111: begin e.data[2] = ~w[2]; e.flags = 3'b100; e.req = "R5"; end
            4'b1110: begin e.data[3] = ~w[3]; e.flags = 3'b100; e.req = "R5"; end
            4'b0001, 4'b0010, 4'b0100, 4'b1000:
                     begin e.flags = 3'b010; e.req = "R6"; end
            default: begin e.flags = 3'b001; e.req = "R7"; end
        endcase
        return e;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_enc(input logic [3:0] d);
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        enc_q.push_back({m_chk(d), d});
    endtask

    task automatic drive_dec(input logic [7:0] w);
        @(negedge clk);
        dec_valid_i = 1'b1;
        dec_word_i  = w;
        dec_q.push_back(m_dec(w));
    endtask

    // Encoder monitor (R1, R2): pops one expected word per valid result.
    always @(negedge clk) begin
        if (rst_n && enc_valid_o) begin
            if (enc_q.size() == 0) check("R2 unexpected enc valid", 16'd1, 16'd0);
            else check("R1/R2 enc word", {8'h0, enc_word_o}, {8'h0, enc_q.pop_front()});
        end
    end

    // Decoder monitor (R3..R8): compares data, syndrome and flags together.
    always @(negedge clk) begin
        if (rst_n && dec_valid_o) begin
            if (dec_q.size() == 0) check("R3 unexpected dec valid", 16'd1, 16'd0);
            else begin
                dec_exp_t e;
                e = dec_q.pop_front();
                check({e.req, "/R3/R8 decode"},
                      {5'b0, dec_fixed_o, dec_parerr_o, dec_uncorr_o, dec_syndrome_o, dec_data_o},
                      {5'b0, e.flags, e.syn, e.data});
            end
        end
    end

    initial begin
        // R10: outputs clear under reset even with valid inputs offered.
        enc_valid_i = 1'b1; enc_data_i = 4'hF;
        dec_valid_i = 1'b1; dec_word_i = 8'hA5;
        repeat (3) @(negedge clk);
        check("R10 reset clears outputs",
              {enc_valid_o, enc_word_o, dec_valid_o, dec_fixed_o, dec_parerr_o, dec_uncorr_o, 4'h0},
              16'h0);
        check("R10 reset clears dec data", {8'h0, dec_syndrome_o, dec_data_o}, 16'h0);
        enc_valid_i = 1'b0; dec_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: every nibble through the encoder, back to back.
        for (int d = 0; d < 16; d++) drive_enc(d[3:0]);
        @(negedge clk);
        enc_valid_i = 1'b0;

        // R3..R8: every nibble clean, with each single flip and each double flip.
        for (int d = 0; d < 16; d++) begin
            for (int a = -1; a < 8; a++) begin
                for (int b = a; b < 8; b++) begin
                    logic [7:0] m;
                    m = '0;
                    if (a >= 0) m[a] = 1'b1;
                    if (b > a) m[b] = 1'b1;
                    if (a < 0 && b >= 0) continue;
                    drive_dec({m_chk(d[3:0]), d[3:0]} ^ m);
                end
            end
        end
        @(negedge clk);
        dec_valid_i = 1'b0;
        @(negedge clk);

        // R9: one known decode, then idle cycles with junk on the inputs.
        drive_dec(8'h5B);
        @(negedge clk);
        dec_valid_i = 1'b0;
        dec_word_i  = 8'hFF;
        enc_valid_i = 1'b0;
        enc_data_i  = 4'h9;
        begin
            dec_exp_t h;
            h = m_dec(8'h5B);
            repeat (3) begin
                @(negedge clk);
                check("R9 dec hold while idle",
                      {3'b0, dec_valid_o, dec_syndrome_o, 4'h0, dec_data_o},
                      {3'b0, 1'b0, h.syn, 4'h0, h.data});
                check("R9 enc idle", {7'h0, enc_valid_o, enc_word_o},
                      {7'h0, 1'b0, m_chk(4'hF), 4'hF});
            end
        end

        // R10: reset mid-run with a word on the inputs.
        dec_valid_i = 1'b1; dec_word_i = 8'h12; rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid-run reset",
              {3'b0, dec_valid_o, dec_syndrome_o, dec_data_o, enc_valid_o, dec_fixed_o,
               dec_parerr_o, dec_uncorr_o}, 16'h0);
        dec_valid_i = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        check("R2/R3 queues drained", {8'h0, 8'(enc_q.size() + dec_q.size())}, 16'h0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule